// File: doc/BRIEF.md
# Nibble-Loaded Pattern Bank Register File

This block holds the eight bank numbers that map the 8 KB picture (pattern) address space onto a larger pattern ROM in 1 KB pieces. Each bank number is 8 bits wide, but the CPU can only load it four bits at a time. Each write updates either the lower or the upper half of one register, and the other half keeps its value. Four 4 KB CPU regions each hold one pair of registers. Inside a region, the low four address lines pick the register of the pair and the half. Each half can be reached at more than one offset, so boards that wire the register-select lines differently all work.

Besides exposing all eight bank numbers, the block takes a picture address and returns the bank number of the 1 KB slot that address falls into. The memory controller uses this to form the physical ROM address. CPU writes take effect on the clock edge that samples them. The lookup is combinational on the stored values.

Top module: `pbank_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, all eight bank registers read 0x00 and the lookup output reads 0x00.
- R2: A write at region offset 0x0 loads data[3:0] into bits [3:0] of the even register of that region, and bits [7:4] keep their value.
- R3: A write at region offset 0x2 or 0x8 loads data[3:0] into bits [7:4] of the even register, and bits [3:0] keep their value.
- R4: A write at region offset 0x1 or 0x4 loads data[3:0] into bits [3:0] of the odd register, and bits [7:4] keep their value.
- R5: A write at region offset 0x3 or 0xC loads data[3:0] into bits [7:4] of the odd register, and bits [3:0] keep their value.
- R6: Address bits [15:12] pick the register pair: 0xB gives registers 0/1, 0xC gives 2/3, 0xD gives 4/5, and 0xE gives 6/7. Address bits [11:4] are ignored.
- R7: Data bits [7:4] never reach any register.
- R8: These leave every register unchanged: a write at offsets 0x5, 0x6, 0x7, 0x9, 0xA, 0xB, 0xD, 0xE or 0xF; a write in a region outside 0xB–0xE; any cycle with the write strobe low.
- R9: The lookup output equals the register indexed by picture address bits [12:10]. Bits [9:0] do not affect it.
- R10: A write becomes visible on the rising clock edge that samples it. During the cycle of that write, the lookup and the register outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | CPU write strobe, one write per high cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data, bits [3:0] used |
| pat_addr | input | 13 | Picture address for the bank lookup |
| bank_q | output | 64 | All bank registers, register n in bits [8n+7:8n] |
| phys_bank | output | 8 | Bank number selected by pat_addr[12:10] |

## Verification
The lookup and a nibble write can target the same register in the same cycle. The bench points pat_addr at a slot and writes to that slot's register in the same cycle. It samples phys_bank before the edge and expects the old value, then samples it after the edge and expects the merged value. It also writes to one register while the lookup is held on a different slot, to show that the unrelated output does not move.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

  localparam int unsigned BANK_IDX_W = 3;

  typedef enum logic [1:0] {
    NIB_NONE = 2'd0,
    NIB_LO   = 2'd1,
    NIB_HI   = 2'd2
  } nib_op_e;

  typedef struct packed {
    logic                  hit;
    logic [BANK_IDX_W-1:0] idx;
    nib_op_e               op;
  } wr_cmd_t;

endpackage

// File: rtl/pbank_rst_sync.sv
module pbank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pbank_decode.sv
module pbank_decode
  import pbank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned NUM_BANKS    = 8,
  parameter logic [3:0]  FIRST_REGION = 4'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_cmd_t           cmd
);

  localparam int unsigned NUM_PAIRS = NUM_BANKS / 2;
  localparam int unsigned PAIR_W    = BANK_IDX_W - 1;

  logic [3:0] region;
  logic [3:0] pair_ofs;
  logic [3:0] sub_ofs;
  logic       region_ok;
  logic       odd_sel;
  nib_op_e    op_sel;
  logic       unused_mid;

  assign region     = wr_addr[ADDR_W-1 -: 4];
  assign sub_ofs    = wr_addr[3:0];
  assign pair_ofs   = region - FIRST_REGION;
  assign region_ok  = (region >= FIRST_REGION) && ({1'b0, pair_ofs} < 5'(NUM_PAIRS));
  assign unused_mid = ^wr_addr[ADDR_W-5:4];

  always_comb begin
    odd_sel = 1'b0;
    op_sel  = NIB_NONE;
    unique case (sub_ofs)
      4'h0:         begin odd_sel = 1'b0; op_sel = NIB_LO; end
      4'h2, 4'h8:   begin odd_sel = 1'b0; op_sel = NIB_HI; end
      4'h1, 4'h4:   begin odd_sel = 1'b1; op_sel = NIB_LO; end
      4'h3, 4'hC:   begin odd_sel = 1'b1; op_sel = NIB_HI; end
      default:      begin odd_sel = 1'b0; op_sel = NIB_NONE; end
    endcase
  end

  always_comb begin
    cmd.hit = wr_en && region_ok && (op_sel != NIB_NONE);
    cmd.idx = {pair_ofs[PAIR_W-1:0], odd_sel};
    cmd.op  = cmd.hit ? op_sel : NIB_NONE;
  end

  AST_NO_STRAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !cmd.hit) else $error("write command without strobe"); // R8

endmodule

// File: rtl/pbank_nibreg.sv
module pbank_nibreg #(
  parameter int unsigned BANK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BANK_W/2-1:0] nib_in,
  output logic [BANK_W-1:0]   q
);

  localparam int unsigned NIB_W = BANK_W / 2;

  logic [NIB_W-1:0] lo_q, lo_d;
  logic [NIB_W-1:0] hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo) lo_d = nib_in;
    if (wr_hi) hi_d = nib_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= lo_d;
      if (wr_hi) hi_q <= hi_d;
    end
  end

  assign q = {hi_q, lo_q};

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (q[BANK_W-1:NIB_W] == $past(q[BANK_W-1:NIB_W])))
    else $error("low write disturbed upper half"); // R2
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (q[NIB_W-1:0] == $past(q[NIB_W-1:0])))
    else $error("high write disturbed lower half"); // R3
  AST_HI_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (q[BANK_W-1:NIB_W] == $past(nib_in)))
    else $error("upper half not loaded"); // R5

endmodule

// File: rtl/pbank_select.sv
module pbank_select #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_BANKS*BANK_W-1:0] banks,
  input  logic [IDX_W-1:0]            slot,
  output logic [BANK_W-1:0]           sel
);

  logic [BANK_W-1:0] bank_arr [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
    assign bank_arr[g] = banks[g*BANK_W +: BANK_W];
  end

  assign sel = bank_arr[slot];

endmodule

// File: rtl/pbank_regfile.sv
module pbank_regfile
  import pbank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PAT_W        = 13,
  parameter int unsigned NUM_BANKS    = 8,
  parameter int unsigned BANK_W       = 8,
  parameter logic [3:0]  FIRST_REGION = 4'hB
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [PAT_W-1:0]            pat_addr,
  output logic [NUM_BANKS*BANK_W-1:0] bank_q,
  output logic [BANK_W-1:0]           phys_bank
);

  localparam int unsigned NIB_W = BANK_W / 2;
  localparam int unsigned IDX_W = BANK_IDX_W;

  logic             rst_sync_n;
  wr_cmd_t          cmd;
  logic [IDX_W-1:0] slot;
  logic             unused_in;

  assign slot      = pat_addr[PAT_W-1 -: IDX_W];
  assign unused_in = ^{wr_data[DATA_W-1:NIB_W], pat_addr[PAT_W-IDX_W-1:0]};

  pbank_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbank_decode #(
    .ADDR_W       (ADDR_W),
    .NUM_BANKS    (NUM_BANKS),
    .FIRST_REGION (FIRST_REGION)
  ) i_decode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel_this;
    assign sel_this = cmd.hit && (cmd.idx == IDX_W'(g));

    pbank_nibreg #(.BANK_W(BANK_W)) i_reg (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_lo  (sel_this && (cmd.op == NIB_LO)),
      .wr_hi  (sel_this && (cmd.op == NIB_HI)),
      .nib_in (wr_data[NIB_W-1:0]),
      .q      (bank_q[g*BANK_W +: BANK_W])
    );
  end

  pbank_select #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .IDX_W     (IDX_W)
  ) i_select (
    .banks (bank_q),
    .slot  (slot),
    .sel   (phys_bank)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(bank_q)) else $error("registers moved without a write"); // R8
  AST_OUT_RANGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_addr[ADDR_W-1 -: 4] < FIRST_REGION) |=> $stable(bank_q))
    else $error("write below register regions took effect"); // R6
  AST_LOOKUP_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_bank == bank_q[slot*BANK_W +: BANK_W]) else $error("lookup mismatch"); // R9

endmodule

// File: tb/test_pbank_regfile.sv
`timescale 1ns/1ps
module test_pbank_regfile;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [12:0] pat_addr;
  logic [63:0] bank_q;
  logic [7:0]  phys_bank;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // {address, data, register index, expected register value after write}
  localparam logic [39:0] VEC [20] = '{
    40'hB000_35_00_05, // R2 R7
    40'hB002_A7_00_75, // R3 R7
    40'hB008_0C_00_C5, // R3 alias
    40'hB001_09_01_09, // R4
    40'hB004_F3_01_03, // R4 alias R7
    40'hB003_0E_01_E3, // R5
    40'hB00C_42_01_23, // R5 alias
    40'hC000_01_02_01, // R6
    40'hC008_0F_02_F1,
    40'hC004_06_03_06,
    40'hC003_0B_03_B6,
    40'hD000_0D_04_0D,
    40'hD002_08_04_8D,
    40'hD001_02_05_02,
    40'hD00C_07_05_72,
    40'hE000_04_06_04,
    40'hE00C_0A_07_A0,
    40'hE7F1_05_07_A5, // R6 middle bits ignored
    40'hE002_09_06_94,
    40'hB5A0_0F_00_CF
  };
  localparam logic [7:0] FINAL [8] = '{8'hCF, 8'h23, 8'hF1, 8'hB6, 8'h8D, 8'h72, 8'h94, 8'hA5};

  pbank_regfile i_pbank_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pat_addr  (pat_addr),
    .bank_q    (bank_q),
    .phys_bank (phys_bank)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 16'h0000; wr_data = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [63:0] snap;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pat_addr = '0;
    #2 rst_n = 1'b0;
    #20;
    check("R1 during reset", bank_q, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset", bank_q, 64'h0);
    check("R1 lookup", {56'h0, phys_bank}, 64'h0);

    foreach (VEC[i]) begin
      logic [7:0] idx, exv;
      idx = VEC[i][15:8];
      exv = VEC[i][7:0];
      cpu_write(VEC[i][39:24], VEC[i][23:16]);
      check("R2-5 vector reg", {56'h0, bank_q[idx*8 +: 8]}, {56'h0, exv});
      pat_addr = {idx[2:0], 10'h155};
      #1;
      check("R9 vector lookup", {56'h0, phys_bank}, {56'h0, exv});
    end

    for (int k = 0; k < 8; k++) begin
      check("R6 final reg", {56'h0, bank_q[k*8 +: 8]}, {56'h0, FINAL[k]});
      pat_addr = {3'(k), 10'h3FF};
      #1;
      check("R9 final lookup", {56'h0, phys_bank}, {56'h0, FINAL[k]});
    end

    snap = bank_q;
    for (int o = 0; o < 16; o++) begin
      if (o == 5 || o == 6 || o == 7 || o == 9 || o == 10 || o == 11 ||
          o == 13 || o == 14 || o == 15) begin
        cpu_write(16'hB000 | 16'(o), 8'h0A);
        cpu_write(16'hE000 | 16'(o), 8'h05);
      end
    end
    check("R8 undecoded offsets", bank_q, snap);
    cpu_write(16'h9000, 8'h0F);
    cpu_write(16'hA002, 8'h0F);
    cpu_write(16'hF001, 8'h0F);
    cpu_write(16'h8003, 8'h0F);
    check("R8 other regions", bank_q, snap);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 16'hB000; wr_data = 8'h01;
    @(negedge clk);
    check("R8 strobe low", bank_q, snap);

    // R10: write and lookup on the same register in the same cycle
    pat_addr = 13'h0000;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'hB000; wr_data = 8'h03;
    #4;
    check("R10 old value before edge", {56'h0, phys_bank}, 64'hCF);
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 new value after edge", {56'h0, phys_bank}, 64'hC3);
    pat_addr = 13'h1C00;
    cpu_write(16'hB001, 8'h0B);
    check("R10 other slot unmoved", {56'h0, phys_bank}, 64'hA5);
    check("R4 concurrent target", {56'h0, bank_q[15:8]}, 64'h2B);

    do_reset();
    check("R1 reset mid-run", bank_q, 64'h0);
    check("R1 lookup mid-run", {56'h0, phys_bank}, 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule